// File: doc/BRIEF.md
# Calendar alarm match unit

This block watches the running calendar of a real-time clock and raises an alarm when the current time reaches a programmed point. It receives four BCD time fields: minute, hour (24-hour), day of month and weekday. It also receives four alarm bytes, one per field. Bit 7 of each alarm byte removes that field from the comparison. The lower bits hold the BCD value that the field must equal.

The comparison runs only in the cycle where the time keeper pulses its minute-update strobe. An alarm event occurs when every field that is not removed equals its alarm value. An event sets a sticky alarm flag, which stays set until software issues a flag-clear write. The active-low interrupt request is low while the flag is set and the interrupt enable is 1. With the enable at 0, software can poll the flag and the interrupt line does not move.

Top module: `alarm_match_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), alarm_flag is 0 and irq_n is 1.
- R2: Only the value bits of each field take part in a comparison: bits 6:0 for the minute, bits 5:0 for the hour and the day of month, and bits 2:0 for the weekday. The other bits below bit 7 of the alarm bytes are ignored, and so are all bits above the value bits of the current-time inputs.
- R3: A field whose alarm byte has bit 7 = 1 is excluded and cannot block a match. A field with bit 7 = 0 must be equal for a match.
- R4: When upd_stb is 1 and all included fields are equal, an alarm event occurs and alarm_flag reads 1 from the next clock cycle on.
- R5: When all four alarm bytes have bit 7 = 1, no alarm event occurs, whatever the time.
- R6: Once set, alarm_flag stays 1 until a cycle with flag_clr = 1. It then reads 0 from the next cycle on, unless R7 applies.
- R7: If flag_clr and an alarm event occur in the same cycle, alarm_flag is 1 afterwards.
- R8: irq_n is 0 exactly while alarm_flag is 1 and irq_en is 1, with no added delay. Clearing either one releases irq_n in the same cycle.
- R9: With irq_en = 0, a match still sets alarm_flag, and irq_n stays 1.
- R10: With upd_stb = 0, a matching time produces no event, so a single strobe gives exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | One-cycle minute-update strobe; comparison is made only then |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD, 24-hour |
| now_mday | input | 8 | Current day of month, BCD |
| now_wday | input | 8 | Current weekday, 0..6 |
| alm_min | input | 8 | Minute alarm byte; bit 7 excludes |
| alm_hour | input | 8 | Hour alarm byte; bit 7 excludes |
| alm_mday | input | 8 | Day-of-month alarm byte; bit 7 excludes |
| alm_wday | input | 8 | Weekday alarm byte; bit 7 excludes |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Flag-clear write, one cycle |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps all sixteen exclusion patterns against every minute value combined with near and far hour, day and weekday values. A design that compares an excluded field, or that ignores an included one, shows a wrong flag in this sweep. The all-excluded pattern is checked separately. A design that treats it as a match would set the flag every minute.

Directed cases cover further faults:
- Junk in the unused bits of the alarm bytes and time inputs, which a full-byte comparator would trip on.
- A clear arriving together with a match, where a clear-first priority would lose the event.
- A matching time held without a strobe, which a level-sensitive design would flag.
- Toggling of the enable around a set flag, which shows whether irq_n follows the flag and mask at once.

// File: rtl/alarm_pkg.sv
// Package: shared constants and types for the calendar alarm match unit.
// Assumes four alarm fields and byte-wide alarm registers whose top bit
// excludes the field from comparison.
package alarm_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int BYTE_W     = 8;
    localparam int EXCL_BIT   = BYTE_W - 1;

    // Field order inside the packed arrays used between submodules.
    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_MDAY = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_bytes_t;
    typedef logic [NUM_FIELDS-1:0]             field_bits_t;

endpackage

// File: rtl/alarm_field_cmp.sv
// Module: alarm_field_cmp
// Compares one BCD time field against its alarm byte. Only the low VAL_W
// bits are compared; bit 7 of the alarm byte marks the field as excluded.
// Assumes VAL_W is between 1 and 7.
module alarm_field_cmp #(
    parameter int VAL_W = 7
) (
    input  logic [alarm_pkg::BYTE_W-1:0] now_i,
    input  logic [alarm_pkg::BYTE_W-1:0] alm_i,
    output logic                         incl_o,
    output logic                         equal_o
);
    import alarm_pkg::*;

    // Purpose: decode inclusion and value equality of this field.
    always_comb begin
        incl_o  = ~alm_i[EXCL_BIT];
        equal_o = (now_i[VAL_W-1:0] == alm_i[VAL_W-1:0]);
    end

    // Bits outside the value range are deliberately not compared.
    logic unused_now_bits;
    assign unused_now_bits = ^now_i[BYTE_W-1:VAL_W];

    if (VAL_W < EXCL_BIT) begin : g_alm_pad
        logic unused_alm_bits;
        assign unused_alm_bits = ^alm_i[EXCL_BIT-1:VAL_W];
    end

endmodule

// File: rtl/alarm_match_core.sv
// Module: alarm_match_core
// Instantiates one comparator per field and forms the one-cycle alarm event:
// strobe present, at least one field included, and all included fields equal.
// Assumes the update strobe lasts one cycle per minute.
module alarm_match_core #(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int MDAY_W = 6,
    parameter int WDAY_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_stb_i,
    input  alarm_pkg::field_bytes_t  now_i,
    input  alarm_pkg::field_bytes_t  alm_i,
    output logic                     evt_o
);
    import alarm_pkg::*;

    field_bits_t incl;
    field_bits_t equal;
    logic        any_incl;
    logic        all_ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int FW = (g == int'(FLD_MIN))  ? MIN_W  :
                            (g == int'(FLD_HOUR)) ? HOUR_W :
                            (g == int'(FLD_MDAY)) ? MDAY_W : WDAY_W;
        alarm_field_cmp #(.VAL_W(FW)) i_cmp (
            .now_i   (now_i[g]),
            .alm_i   (alm_i[g]),
            .incl_o  (incl[g]),
            .equal_o (equal[g])
        );
    end

    // Purpose: combine per-field results into a single strobed event.
    always_comb begin
        any_incl = |incl;
        all_ok   = &(equal | ~incl);
        evt_o    = upd_stb_i & any_incl & all_ok;
    end

    // R5
    all_excluded_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_i[0][EXCL_BIT] && alm_i[1][EXCL_BIT] && alm_i[2][EXCL_BIT]
         && alm_i[3][EXCL_BIT]) |-> !evt_o);

endmodule

// File: rtl/alarm_flag_ctrl.sv
// Module: alarm_flag_ctrl
// Holds the sticky alarm flag and drives the masked active-low interrupt.
// An event has priority over a same-cycle clear. Assumes evt_i is a
// one-cycle pulse from the match core.
module alarm_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_n_o
);
    logic flag_q;

    // Purpose: set on event, clear on write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (evt_i)      flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Purpose: expose the flag and the masked interrupt request.
    always_comb begin
        flag_o  = flag_q;
        irq_n_o = ~(flag_q & irq_en_i);
    end

    // R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_q);
    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !evt_i) |=> !flag_q);
    // R7
    evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && evt_i) |=> flag_q);
    // R10
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !evt_i) |=> !flag_q);

endmodule

// File: rtl/alarm_match_unit.sv
// Module: alarm_match_unit (top)
// Calendar alarm: compares minute, hour, day of month and weekday against
// four alarm bytes on each minute strobe, sets a sticky flag on a match and
// drives a maskable active-low interrupt. Assumes BCD inputs from the
// time keeper and a one-cycle strobe per minute update.
module alarm_match_unit #(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int MDAY_W = 6,
    parameter int WDAY_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_stb,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_mday,
    input  logic [7:0] now_wday,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_mday,
    input  logic [7:0] alm_wday,
    input  logic       irq_en,
    input  logic       flag_clr,
    output logic       alarm_flag,
    output logic       irq_n
);
    import alarm_pkg::*;

    field_bytes_t now_v;
    field_bytes_t alm_v;
    logic         evt;

    // Purpose: pack the per-field ports in field order.
    always_comb begin
        now_v[FLD_MIN]  = now_min;
        now_v[FLD_HOUR] = now_hour;
        now_v[FLD_MDAY] = now_mday;
        now_v[FLD_WDAY] = now_wday;
        alm_v[FLD_MIN]  = alm_min;
        alm_v[FLD_HOUR] = alm_hour;
        alm_v[FLD_MDAY] = alm_mday;
        alm_v[FLD_WDAY] = alm_wday;
    end

    alarm_match_core #(
        .MIN_W (MIN_W), .HOUR_W(HOUR_W), .MDAY_W(MDAY_W), .WDAY_W(WDAY_W)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_stb_i (upd_stb),
        .now_i     (now_v),
        .alm_i     (alm_v),
        .evt_o     (evt)
    );

    alarm_flag_ctrl i_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .flag_clr_i (flag_clr),
        .irq_en_i   (irq_en),
        .flag_o     (alarm_flag),
        .irq_n_o    (irq_n)
    );

    // R9
    masked_irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);

endmodule

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic [7:0] now_min = '0, now_hour = '0, now_mday = '0, now_wday = '0;
    logic [7:0] alm_min = '0, alm_hour = '0, alm_mday = '0, alm_wday = '0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       alarm_flag;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    alarm_match_unit i_alarm_match_unit (
        .clk, .rst_n, .upd_stb, .now_min, .now_hour, .now_mday, .now_wday,
        .alm_min, .alm_hour, .alm_mday, .alm_wday, .irq_en, .flag_clr,
        .alarm_flag, .irq_n
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one strobe cycle; returns at the negedge after the capturing edge
    task automatic strobe();
        @(negedge clk) upd_stb = 1'b1;
        @(negedge clk) upd_stb = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            summary();
        end
    end

    initial begin
        // Alarm target: 14:30, day 21, weekday 3
        int a_min = 30, a_hr = 14, a_md = 21, a_wd = 3;
        int hrs[2] = '{14, 15};
        int mds[2] = '{21, 22};
        int wds[2] = '{3, 5};

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 flag after reset", alarm_flag, 0);
        check("R1 irq_n after reset", irq_n, 1);
        rst_n = 1'b1;
        irq_en = 1'b1;

        // R3/R4/R5 sweep over all exclusion masks
        for (int m = 0; m < 16; m++) begin
            alm_min  = bcd(a_min) | (m[0] ? 8'h80 : 8'h00);
            alm_hour = bcd(a_hr)  | (m[1] ? 8'h80 : 8'h00);
            alm_mday = bcd(a_md)  | (m[2] ? 8'h80 : 8'h00);
            alm_wday = bcd(a_wd)  | (m[3] ? 8'h80 : 8'h00);
            for (int cm = 0; cm < 60; cm++)
                for (int k = 0; k < 8; k++) begin
                    bit exp;
                    @(negedge clk);
                    now_min  = bcd(cm);
                    now_hour = bcd(hrs[k % 2]);
                    now_mday = bcd(mds[(k / 2) % 2]);
                    now_wday = bcd(wds[k / 4]);
                    exp = (m != 15) &&
                          (m[0] || cm == a_min) &&
                          (m[1] || hrs[k % 2] == a_hr) &&
                          (m[2] || mds[(k / 2) % 2] == a_md) &&
                          (m[3] || wds[k / 4] == a_wd);
                    strobe();
                    if (m == 15) check("R5 all excluded", alarm_flag, 0);
                    else         check("R3 R4 sweep flag", alarm_flag, int'(exp));
                    check("R8 irq follows flag", irq_n, int'(!exp));
                    clear_flag();
                end
        end

        // R2 junk in unused bits
        @(negedge clk);
        alm_min  = 8'h30; alm_hour = 8'h54; alm_mday = 8'h61; alm_wday = 8'h7B;
        now_min  = 8'hB0; now_hour = 8'hD4; now_mday = 8'hE1; now_wday = 8'hF3;
        strobe();
        check("R2 unused bits ignored", alarm_flag, 1);
        clear_flag();
        now_wday = 8'h04;
        strobe();
        check("R2 value bits compared", alarm_flag, 0);

        // R10 matching time without strobe
        now_wday = 8'h03;
        repeat (5) @(negedge clk);
        check("R10 no strobe no event", alarm_flag, 0);
        strobe();
        check("R10 strobe gives event", alarm_flag, 1);

        // R6 sticky and clear
        repeat (4) @(negedge clk);
        check("R6 flag sticky", alarm_flag, 1);
        clear_flag();
        check("R6 clear drops flag", alarm_flag, 0);
        repeat (3) @(negedge clk);
        check("R10 one event per strobe", alarm_flag, 0);

        // R7 clear in same cycle as event
        @(negedge clk) begin upd_stb = 1'b1; flag_clr = 1'b1; end
        @(negedge clk) begin upd_stb = 1'b0; flag_clr = 1'b0; end
        check("R7 event beats clear", alarm_flag, 1);

        // R8 mask toggling with the flag set
        irq_en = 1'b0; #1;
        check("R8 enable off releases irq", irq_n, 1);
        irq_en = 1'b1; #1;
        check("R8 enable on asserts irq", irq_n, 0);
        clear_flag();
        check("R8 clear releases irq", irq_n, 1);

        // R9 masked: flag sets, irq stays high
        irq_en = 1'b0;
        strobe();
        check("R9 flag sets while masked", alarm_flag, 1);
        check("R9 irq high while masked", irq_n, 1);
        clear_flag();

        // R1 reset clears a set flag
        irq_en = 1'b1;
        strobe();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 reset clears flag", alarm_flag, 0);
        check("R1 reset releases irq", irq_n, 1);

        finished = 1;
        summary();
    end

endmodule